// File: doc/BRIEF.md
# Priority Interrupt Controller Core

This block is an eight-input priority interrupt controller in the style of the classic PC controller. A processor reaches it through a small register port: a chip select, one address bit, read and write strobes, an 8-bit write bus and an 8-bit read bus. Eight level-sensitive request lines feed a request register. A fixed priority resolver, with line 0 highest and line 7 lowest, selects the winning level. It takes account of the mask register and of the levels currently in service, and it raises a single interrupt output when a request may proceed.

An acknowledge strobe moves the winning level from the request register into the in-service register. During that strobe the block returns a vector, which is the parameter base plus the level number. A non-specific end-of-interrupt command retires the highest-priority in-service level. A control word at the even address does three things. It selects whether even-address reads return the request or the in-service register, and that choice is sticky. It can arm a one-shot poll read, which then works as an acknowledge. It enters or leaves special mask mode. In that mode the in-service levels no longer block requests of lower priority.

The base vector and the operating mode are fixed by parameters. The block has no initialization sequence.

Top module: `prio_intc`

## Requirements
- R1: After reset the request, in-service and mask registers are zero. Even-address reads return the request register, poll is off, special mask mode is off, and `irq_out` is low.
- R2: Request register bit i equals `irq_req[i]` as sampled at the previous clock edge. The exception is the bit taken by an acknowledge at that edge, which reads 0 for one cycle. The mask register never changes the request register.
- R3: A write at address 1 loads the mask register from `wdata`. A read at address 1 returns the mask register, whatever the status selection or poll state.
- R4: A write at address 0 with `wdata[4:3]=01` is the control word. If its bit 1 is 1, bit 0 selects the register that even reads return: 0 for request and 1 for in-service. If bit 1 is 0, the selection is kept over any number of reads and writes.
- R5: A control word with bit 2 = 1 arms poll. The next read at address 0 returns `8'h80 | level` when a request may proceed, and 0 otherwise. That read acts as an acknowledge and disarms poll. A control word with bit 2 = 0 disarms poll.
- R6: While `ack` is high, `ack_vec` is `BASE_VEC + level` of the winning request. At that clock edge the level's in-service bit is set and its request bit is cleared. With no winner, `ack_vec` is `BASE_VEC + 7` and no register changes.
- R7: The winner is the lowest-numbered level that is set in the request register, clear in the mask register and not blocked. `irq_out` is high exactly when a winner exists.
- R8: Outside special mask mode, an in-service bit at level k blocks levels k through 7.
- R9: A write at address 0 with `wdata[4:3]=00` clears the lowest-numbered set in-service bit. In-service bits are cleared by nothing else.
- R10: A control word with bit 6 = 1 sets special mask mode to the value of bit 5. With bit 6 = 0 the mode is kept. In special mask mode a level is blocked only by its own in-service bit.
- R11: `rdata` is zero whenever no read is addressed to the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select for the register port |
| addr | input | 1 | Register address bit |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational during a read |
| irq_req | input | 8 | Level-sensitive request lines |
| ack | input | 1 | Interrupt acknowledge strobe |
| ack_vec | output | 8 | Vector of the level served by the current acknowledge |
| irq_out | output | 1 | Interrupt output to the processor |

## Verification
The checks assume that each cycle carries at most one operation. That operation is a read, a write or an acknowledge. Read and write never come together, and an acknowledge never coincides with a poll read or an end-of-interrupt write. The bench keeps to this by drawing one operation per cycle from a closed set. Under that condition the checks can take a newly set in-service bit to be exactly one. They can also assume that a cleared in-service bit always follows an end-of-interrupt write.

// File: rtl/intc_pkg.sv
package intc_pkg;

   typedef enum logic {
      SEL_REQ = 1'b0,
      SEL_SVC = 1'b1
   } stat_sel_t;

   typedef struct packed {
      logic mask_wr;
      logic ctl_wr;
      logic eoi_wr;
      logic mask_rd;
      logic poll_rd;
      logic stat_rd;
   } bus_dec_t;

   localparam int CW_SVC  = 0;
   localparam int CW_RSEL = 1;
   localparam int CW_POLL = 2;
   localparam int CW_SMV  = 5;
   localparam int CW_SMEN = 6;

endpackage

// File: rtl/intc_bus_dec.sv
module intc_bus_dec
   import intc_pkg::*;
(
   input  logic       sel,
   input  logic       addr,
   input  logic       rd,
   input  logic       wr,
   input  logic [1:0] kind,
   input  logic       poll_armed,
   output bus_dec_t   dec
);
   logic even;

   always_comb begin
      even        = sel & ~addr;
      dec.mask_wr = sel & addr & wr;
      dec.mask_rd = sel & addr & rd;
      dec.ctl_wr  = even & wr & (kind == 2'b01);
      dec.eoi_wr  = even & wr & (kind == 2'b00);
      dec.poll_rd = even & rd & poll_armed;
      dec.stat_rd = even & rd & ~poll_armed;
   end
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
   parameter int N = 8
) (
   input  logic [N-1:0] vec,
   output logic [N-1:0] first
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      if (i == 0) begin : g_top
         assign first[i] = vec[i];
      end else begin : g_rest
         assign first[i] = vec[i] & ~(|vec[i-1:0]);
      end
   end
endmodule

// File: rtl/intc_resolver.sv
module intc_resolver #(
   parameter int N  = 8,
   parameter int LW = $clog2(N)
) (
   input  logic [N-1:0]  irr,
   input  logic [N-1:0]  isr,
   input  logic [N-1:0]  imr,
   input  logic          smm,
   output logic [N-1:0]  win_oh,
   output logic [LW-1:0] win_idx,
   output logic          win_any,
   output logic [N-1:0]  svc_top_oh
);
   logic [N-1:0] blocked;
   logic [N-1:0] allow;
   logic [N-1:0] eligible;

   for (genvar i = 0; i < N; i++) begin : g_blk
      assign blocked[i] = |isr[i:0];
   end

   always_comb begin
      allow    = smm ? ~isr : ~blocked;
      eligible = irr & ~imr & allow;
      win_any  = |eligible;
   end

   intc_prio_enc #(.N(N)) u_win (
      .vec   (eligible),
      .first (win_oh)
   );

   intc_prio_enc #(.N(N)) u_svc (
      .vec   (isr),
      .first (svc_top_oh)
   );

   always_comb begin
      win_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (win_oh[i]) win_idx = win_idx | LW'(i);
      end
   end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import intc_pkg::*;
#(
   parameter int             NUM_IRQ  = 8,
   parameter int             DATA_W   = 8,
   parameter logic [DATA_W-1:0] BASE_VEC = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              addr,
   input  logic              rd,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic              ack,
   output logic [DATA_W-1:0] ack_vec,
   output logic              irq_out
);
   localparam int LVL_W  = $clog2(NUM_IRQ);
   localparam int PAD_W  = DATA_W - 1 - LVL_W;

   if (NUM_IRQ != DATA_W) begin : g_bad_width
      $error("prio_intc: NUM_IRQ must equal DATA_W");
   end
   if ((int'(BASE_VEC) % NUM_IRQ) != 0) begin : g_bad_base
      $error("prio_intc: BASE_VEC must be aligned to NUM_IRQ");
   end
   if (DATA_W < 7) begin : g_bad_data
      $error("prio_intc: control word needs at least 7 data bits");
   end

   logic [NUM_IRQ-1:0] irr_q, isr_q, imr_q;
   stat_sel_t          rdsel_q;
   logic               poll_q;
   logic               smm_q;

   bus_dec_t           dec;
   logic [NUM_IRQ-1:0] win_oh;
   logic [LVL_W-1:0]   win_idx;
   logic               win_any;
   logic [NUM_IRQ-1:0] svc_top_oh;
   logic               take;
   logic [NUM_IRQ-1:0] take_oh;
   logic [NUM_IRQ-1:0] eoi_oh;
   logic [LVL_W-1:0]   vec_lvl;

   intc_bus_dec u_dec (
      .sel        (sel),
      .addr       (addr),
      .rd         (rd),
      .wr         (wr),
      .kind       (wdata[4:3]),
      .poll_armed (poll_q),
      .dec        (dec)
   );

   intc_resolver #(.N(NUM_IRQ), .LW(LVL_W)) u_res (
      .irr        (irr_q),
      .isr        (isr_q),
      .imr        (imr_q),
      .smm        (smm_q),
      .win_oh     (win_oh),
      .win_idx    (win_idx),
      .win_any    (win_any),
      .svc_top_oh (svc_top_oh)
   );

   always_comb begin
      take    = (ack | dec.poll_rd) & win_any;
      take_oh = take ? win_oh : '0;
      eoi_oh  = dec.eoi_wr ? svc_top_oh : '0;
      vec_lvl = win_any ? win_idx : LVL_W'(NUM_IRQ - 1);
      ack_vec = BASE_VEC | DATA_W'(vec_lvl);
      irq_out = win_any;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q <= '0;
         isr_q <= '0;
      end else begin
         irr_q <= irq_req & ~take_oh;
         isr_q <= (isr_q & ~eoi_oh) | take_oh;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imr_q   <= '0;
         rdsel_q <= SEL_REQ;
         poll_q  <= 1'b0;
         smm_q   <= 1'b0;
      end else begin
         if (dec.mask_wr) imr_q <= wdata[NUM_IRQ-1:0];
         if (dec.ctl_wr && wdata[CW_RSEL]) rdsel_q <= stat_sel_t'(wdata[CW_SVC]);
         if (dec.ctl_wr) poll_q <= wdata[CW_POLL];
         else if (dec.poll_rd) poll_q <= 1'b0;
         if (dec.ctl_wr && wdata[CW_SMEN]) smm_q <= wdata[CW_SMV];
      end
   end

   always_comb begin
      rdata = '0;
      if (dec.mask_rd) begin
         rdata = DATA_W'(imr_q);
      end else if (dec.poll_rd) begin
         rdata = win_any ? {1'b1, {PAD_W{1'b0}}, win_idx} : '0;
      end else if (dec.stat_rd) begin
         rdata = (rdsel_q == SEL_SVC) ? DATA_W'(isr_q) : DATA_W'(irr_q);
      end
   end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
   parameter int N = 8,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sel,
   input logic          addr,
   input logic          rd,
   input logic          wr,
   input logic [1:0]    wd_kind,
   input logic          wd_rsel,
   input logic [DW-1:0] rdata,
   input logic          ack,
   input logic          irq_out,
   input logic [N-1:0]  irr,
   input logic [N-1:0]  isr,
   input logic [N-1:0]  imr,
   input logic          rdsel,
   input logic          poll,
   input logic          eoi_wr
);
   localparam int LW = $clog2(N);

   logic ctl_rsel_wr;
   assign ctl_rsel_wr = sel && !addr && wr && (wd_kind == 2'b01) && wd_rsel;

   assert_mask_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && rd && addr) |-> (rdata == DW'(imr)));

   assert_sel_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctl_rsel_wr) |-> $stable(rdsel));

   assert_poll_format_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && rd && !addr && poll) |-> ((rdata[DW-2:LW] == '0) && (rdata[DW-1] == irq_out)));

   assert_ack_one_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_out) |=> ($countones(isr & ~$past(isr)) == 1));

   assert_irq_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (|(irr & ~imr)));

   assert_svc_clear_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(isr) & ~isr)) |-> $past(eoi_wr));

   assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel && rd) |-> (rdata == '0));
endmodule

bind prio_intc intc_chk #(.N(NUM_IRQ), .DW(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel     (sel),
   .addr    (addr),
   .rd      (rd),
   .wr      (wr),
   .wd_kind (wdata[4:3]),
   .wd_rsel (wdata[1]),
   .rdata   (rdata),
   .ack     (ack),
   .irq_out (irq_out),
   .irr     (irr_q),
   .isr     (isr_q),
   .imr     (imr_q),
   .rdsel   (rdsel_q),
   .poll    (poll_q),
   .eoi_wr  (dec.eoi_wr)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       sel, addr, rd, wr, ack;
   logic [7:0] wdata, rdata, irq_req, ack_vec;
   logic       irq_out;

   logic [7:0] m_irr, m_isr, m_imr;
   logic       m_rsel, m_poll, m_smm;
   int         n_vec = 0;
   int         n_bad = 0;
   bit         done = 0;

   localparam logic [7:0] BASE = 8'h20;

   prio_intc uut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .rd(rd), .wr(wr),
      .wdata(wdata), .rdata(rdata), .irq_req(irq_req), .ack(ack),
      .ack_vec(ack_vec), .irq_out(irq_out)
   );

   always #10 clk = ~clk;

   function automatic logic [7:0] elig();
      logic [7:0] e;
      logic       blk;
      blk = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (m_isr[i]) blk = 1'b1;
         e[i] = m_irr[i] & ~m_imr[i] & (m_smm ? ~m_isr[i] : ~blk);
      end
      return e;
   endfunction

   function automatic int lowest(logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return -1;
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   // one bus operation per cycle; entered and left at a falling edge
   task automatic step(input logic s, input logic a, input logic r, input logic w,
                       input logic [7:0] d, input logic [7:0] rq, input logic k,
                       input string tag);
      logic [7:0] e, exp_rd, ack_bit;
      int         lv;
      logic       prd, take;
      string      t;
      sel = s; addr = a; rd = r; wr = w; wdata = d; irq_req = rq; ack = k;
      #5;
      e  = elig();
      lv = lowest(e);
      prd = s && !a && r && m_poll;
      t = (tag != "") ? tag : (m_smm ? "R10" : (m_isr != 0 ? "R8" : "R7"));
      chk(t, {7'd0, irq_out}, {7'd0, lv >= 0});
      exp_rd = 8'h00;
      if (s && r) begin
         if (a) begin
            exp_rd = m_imr; t = (tag != "") ? tag : "R3";
         end else if (m_poll) begin
            exp_rd = (lv >= 0) ? (8'h80 | 8'(lv)) : 8'h00; t = (tag != "") ? tag : "R5";
         end else begin
            exp_rd = m_rsel ? m_isr : m_irr; t = (tag != "") ? tag : (m_rsel ? "R4" : "R2");
         end
      end else t = (tag != "") ? tag : "R11";
      chk(t, rdata, exp_rd);
      if (k) chk((tag != "") ? tag : "R6", ack_vec, BASE + 8'((lv >= 0) ? lv : 7));
      @(posedge clk);
      take = (k || prd) && (lv >= 0);
      ack_bit = take ? (8'h01 << lv) : 8'h00;
      m_irr = rq & ~ack_bit;
      if (s && !a && w && d[4:3] == 2'b00 && m_isr != 0)
         m_isr = m_isr & ~(8'h01 << lowest(m_isr));
      m_isr = m_isr | ack_bit;
      if (s && a && w) m_imr = d;
      if (s && !a && w && d[4:3] == 2'b01) begin
         if (d[1]) m_rsel = d[0];
         m_poll = d[2];
         if (d[6]) m_smm = d[5];
      end else if (prd) m_poll = 1'b0;
      @(negedge clk);
   endtask

   task automatic idle(logic [7:0] rq, string tag);
      step(0, 0, 0, 0, 8'h00, rq, 0, tag);
   endtask
   task automatic rd_even(logic [7:0] rq, string tag);
      step(1, 0, 1, 0, 8'h00, rq, 0, tag);
   endtask
   task automatic rd_odd(logic [7:0] rq, string tag);
      step(1, 1, 1, 0, 8'h00, rq, 0, tag);
   endtask
   task automatic wr_reg(logic a, logic [7:0] d, logic [7:0] rq, string tag);
      step(1, a, 0, 1, d, rq, 0, tag);
   endtask
   task automatic do_ack(logic [7:0] rq, string tag);
      step(0, 0, 0, 0, 8'h00, rq, 1, tag);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rq;
      sel = 0; addr = 0; rd = 0; wr = 0; wdata = 0; irq_req = 0; ack = 0;
      rst_n = 0;
      m_irr = 0; m_isr = 0; m_imr = 0; m_rsel = 0; m_poll = 0; m_smm = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      rd_even(8'h00, "R1");
      rd_odd(8'h00, "R1");
      // R2 / R3: request register ignores mask
      idle(8'h24, "R2");
      wr_reg(1, 8'h24, 8'h24, "R3");
      rd_even(8'h24, "R2");
      rd_odd(8'h24, "R3");
      idle(8'h24, "R7");
      wr_reg(1, 8'h00, 8'h24, "R3");
      // R6: acknowledge level 2
      do_ack(8'h24, "R6");
      // R4: select in-service, sticky over reads
      wr_reg(0, 8'h0B, 8'h24, "R4");
      rd_even(8'h24, "R4");
      rd_even(8'h24, "R4");
      idle(8'h24, "R8");
      idle(8'h25, "R8");
      idle(8'h25, "R7");
      // R10: special mask mode lets level 5 through beside ISR 2
      wr_reg(0, 8'h68, 8'h25, "R10");
      do_ack(8'h25, "R10");
      do_ack(8'h25, "R10");
      rd_even(8'h25, "R10");
      wr_reg(0, 8'h48, 8'h25, "R10");
      idle(8'h25, "R8");
      // R9: non-specific end of interrupt
      wr_reg(0, 8'h20, 8'h25, "R9");
      rd_even(8'h25, "R9");
      // R5: poll read acts as acknowledge, then selection returns
      wr_reg(0, 8'h0C, 8'h25, "R5");
      rd_even(8'h25, "R5");
      rd_even(8'h25, "R5");
      wr_reg(0, 8'h20, 8'h00, "R9");
      wr_reg(0, 8'h20, 8'h00, "R9");
      wr_reg(0, 8'h20, 8'h00, "R9");
      rd_even(8'h00, "R9");
      wr_reg(0, 8'h0C, 8'h00, "R5");
      rd_even(8'h00, "R5");
      // R6: acknowledge with nothing pending
      do_ack(8'h00, "R6");
      rd_even(8'h00, "R6");
      // R4: back to request register
      wr_reg(0, 8'h0A, 8'h81, "R4");
      rd_even(8'h81, "R2");
      // random phase
      void'($urandom(32'd4242));
      rq = 8'h00;
      for (int n = 0; n < 4000; n++) begin
         int op;
         if (($urandom % 4) == 0) rq = 8'($urandom);
         op = int'($urandom % 9);
         case (op)
            0: idle(rq, "");
            1: do_ack(rq, "");
            2: wr_reg(1, 8'($urandom) & 8'($urandom), rq, "");
            3: wr_reg(0, {1'b0, 2'($urandom), 2'b01, 3'($urandom)}, rq, "");
            4: wr_reg(0, 8'h20, rq, "");
            5: rd_odd(rq, "");
            6: do_ack(rq, "");
            default: rd_even(rq, "");
         endcase
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule